// File: doc/BRIEF.md
# Admin Command Queue Engine

This is the device-side engine behind a host-managed queue of administrative commands. The queue is one 4 KiB page of memory. The host places that page by writing its page-frame number to a base register. The page is divided into fixed-size command slots, and the host fills them in consecutive order. To submit work, the host writes its running total of submitted commands to a doorbell register. The engine then works through the commands one at a time, in order, until its executed total matches the doorbell.

For each command, the engine reads the opcode word from the slot. A stub executor produces a status word, which the engine writes back into the same slot. Only after the memory port has accepted that write does the engine advance its executed count. The host sees this count in an event-counter register and polls it until it equals the value it wrote to the doorbell.

Writing zero to the base register resets the device. It drops both counters, abandons any command in progress, releases the queue and pulses a reset output. Every register value and every memory word is carried big-endian.

Top module: `admin_cmd_engine`

## Requirements
- R1: All register traffic is big-endian, with the most significant byte on bits 7:0. This applies to the base and doorbell write data, to the base readback and to the event count. Memory words use the same byte order: the opcode read and the status written.
- R2: Each command is processed at a fixed location. The slot index is the executed count modulo 64. The opcode is read at byte address pfn*4096 + slot*64. The status is written at that address plus 4. Commands are processed strictly in submission order.
- R3: The status written back depends on the opcode. If the opcode word is nonzero, the status is `stub_status`. If the opcode word is zero, the status is `BAD_OP_STATUS` (default 1).
- R4: The executed count increases by exactly one per command. The increase happens in the cycle after the status write is accepted and never earlier. When no other condition stops processing, the event count settles equal to the doorbell value.
- R5: The doorbell and executed counts are 32 bits, and their difference is taken modulo 2^32. A doorbell value below the executed count therefore counts as far ahead.
- R6: While the base register holds zero, doorbell writes are ignored and no memory request is issued.
- R7: Writing zero to the base register has these effects one cycle after the write:
  - both counters read zero;
  - any command in progress is dropped;
  - `dev_reset` is high for exactly that one cycle.
- R8: The doorbell may be at most 64 commands ahead of the executed count. If it is further ahead, `db_err` is high and no new command is fetched. A later doorbell value within range clears `db_err` and processing resumes.
- R9: A memory request holds its address and write flag stable until `mem_ready` accepts it.
- R10: After `rst_n`, the base readback and the event count are zero, `db_err` is low and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_wr | input | 1 | Write strobe for the queue base register |
| base_wdata | input | 32 | Page-frame number, big-endian |
| db_wr | input | 1 | Write strobe for the doorbell |
| db_wdata | input | 32 | Cumulative submitted count, big-endian |
| stub_status | input | 32 | Status the stub executor returns for a nonzero opcode |
| base_rdata | output | 32 | Base register readback, big-endian |
| event_count | output | 32 | Executed-command count, big-endian |
| db_err | output | 1 | Doorbell more than one page of slots ahead |
| dev_reset | output | 1 | One-cycle pulse after a zero base write |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 44 | Byte address |
| mem_wdata | output | 32 | Write data, big-endian |
| mem_ready | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data, big-endian |

## Verification
A table of doorbell values is driven in sequence, and each value exercises a different case:
- a small batch, to test basic processing;
- a repeat of the same value, which must do nothing;
- a batch that wraps the slot index past the page end;
- a value exactly one page ahead, the largest accepted distance;
- a value one beyond a page, which must stall with `db_err`;
- a value behind the executed count, which is far ahead modulo 2^32.

One slot holds a zero opcode, so both status choices are written. A memory model checks the address and data of every transfer. A second run throttles `mem_ready`, to show that held requests and ordering survive stalls. Directed tests then cover three more cases:
- a doorbell write before any base is set;
- a zero base write in the middle of a batch;
- a restart from zero counts after that abort.

// File: rtl/admin_cmd_engine.sv
`timescale 1ns/1ps
module admin_cmd_engine #(
  parameter int          PAGE_SHIFT    = 12,
  parameter int          SLOT_BYTES    = 64,
  parameter int          STATUS_OFF    = 4,
  parameter logic [31:0] BAD_OP_STATUS = 32'h0000_0001,
  localparam int         SLOTS         = (1 << PAGE_SHIFT) / SLOT_BYTES,
  localparam int         SLOT_W        = $clog2(SLOTS),
  localparam int         AW            = 32 + PAGE_SHIFT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_wr,
  input  logic [31:0]   base_wdata,
  input  logic          db_wr,
  input  logic [31:0]   db_wdata,
  input  logic [31:0]   stub_status,
  output logic [31:0]   base_rdata,
  output logic [31:0]   event_count,
  output logic          db_err,
  output logic          dev_reset,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ready,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata
);
  function automatic logic [31:0] bswap(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  typedef enum logic [1:0] {S_IDLE, S_RD, S_RWAIT, S_WR} st_t;

  st_t         st;
  logic [31:0] pfn, db_cnt, exec_cnt, status_q, pending;
  logic [AW-1:0] slot_addr;
  logic        busy;

  assign pending     = db_cnt - exec_cnt;
  assign db_err      = pending > 32'(SLOTS);
  assign busy        = st != S_IDLE;
  assign slot_addr   = {pfn, {PAGE_SHIFT{1'b0}}}
                     + AW'(exec_cnt[SLOT_W-1:0]) * AW'(SLOT_BYTES);
  assign mem_req     = busy && st != S_RWAIT;
  assign mem_we      = st == S_WR;
  assign mem_addr    = slot_addr + (mem_we ? AW'(STATUS_OFF) : AW'(0));
  assign mem_wdata   = bswap(status_q);
  assign base_rdata  = bswap(pfn);
  assign event_count = bswap(exec_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      pfn       <= '0;
      db_cnt    <= '0;
      exec_cnt  <= '0;
      status_q  <= '0;
      dev_reset <= 1'b0;
    end else begin
      dev_reset <= 1'b0;
      if (base_wr && base_wdata == 32'h0) begin
        pfn       <= '0;
        db_cnt    <= '0;
        exec_cnt  <= '0;
        st        <= S_IDLE;
        dev_reset <= 1'b1;
      end else begin
        if (base_wr) pfn <= bswap(base_wdata);
        if (db_wr && pfn != 32'h0) db_cnt <= bswap(db_wdata);
        case (st)
          S_IDLE:  if (pfn != 32'h0 && pending != 32'h0 && !db_err) st <= S_RD;
          S_RD:    if (mem_ready) st <= S_RWAIT;
          S_RWAIT: if (mem_rvalid) begin
                     status_q <= (bswap(mem_rdata) == 32'h0) ? BAD_OP_STATUS : stub_status;
                     st       <= S_WR;
                   end
          S_WR:    if (mem_ready) begin
                     exec_cnt <= exec_cnt + 32'd1;
                     st       <= S_IDLE;
                   end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/admin_cmd_engine_chk.sv
`timescale 1ns/1ps
module admin_cmd_engine_chk #(
  parameter int AW = 44
) (
  input logic          clk,
  input logic          rst_n,
  input logic          base_wr,
  input logic [31:0]   base_wdata,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic          db_err,
  input logic          busy,
  input logic [31:0]   exec_cnt,
  input logic [31:0]   db_cnt,
  input logic [31:0]   pfn,
  input logic          dev_reset
);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready && !base_wr) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R4
  count_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(exec_cnt) |-> ($past(mem_req && mem_we && mem_ready) || $past(base_wr)));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(exec_cnt) && !$past(base_wr)) |-> (exec_cnt == $past(exec_cnt) + 32'd1));

  // R6
  zero_base_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pfn == 32'h0) |-> (exec_cnt == 32'h0 && db_cnt == 32'h0 && !mem_req));

  // R7
  base_zero_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (base_wr && base_wdata == 32'h0) |=> (dev_reset && exec_cnt == 32'h0 && !mem_req));

  // R8
  err_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (db_err && !busy) |=> !mem_req);
endmodule

bind admin_cmd_engine admin_cmd_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_wdata(base_wdata),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .db_err(db_err), .busy(busy), .exec_cnt(exec_cnt), .db_cnt(db_cnt),
  .pfn(pfn), .dev_reset(dev_reset)
);

// File: tb/test_admin_cmd_engine.sv
`timescale 1ns/1ps
module test_admin_cmd_engine;
  localparam int AW = 44;
  localparam logic [31:0] BAD = 32'h0000_0001;
  localparam logic [31:0] PFN = 32'h0001_2345;
  // {doorbell, expected count, expected error}
  localparam logic [64:0] VEC [8] = '{
    {32'd3,   32'd3,  1'b0}, {32'd3,  32'd3,  1'b0},
    {32'd10,  32'd10, 1'b0}, {32'd74, 32'd74, 1'b0},
    {32'd139, 32'd74, 1'b1}, {32'd80, 32'd80, 1'b0},
    {32'd5,   32'd80, 1'b1}, {32'd81, 32'd81, 1'b0}};

  logic clk = 0, rst_n = 0;
  logic base_wr = 0, db_wr = 0, mem_ready = 1, mem_rvalid = 0;
  logic [31:0] base_wdata = 0, db_wdata = 0, stub_status = 32'h0000_00A5, mem_rdata = 0;
  logic [31:0] base_rdata, event_count, mem_wdata;
  logic db_err, dev_reset, mem_req, mem_we;
  logic [AW-1:0] mem_addr;

  int checks = 0, fails = 0, mem_errs = 0, reqs = 0, writes = 0, cyc = 0;
  logic [31:0] exp_exec = 0, cur_pfn = 0;
  logic stall = 0, rv_pend = 0, done = 0;
  logic [5:0] rd_slot = 0;
  logic [31:0] op_mem [64];

  always #10 clk = ~clk;

  admin_cmd_engine i_admin_cmd_engine (.*);

  function automatic logic [31:0] sw(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  // memory model, acting away from the active edge
  always @(negedge clk) begin
    logic [AW-1:0] ea;
    logic [31:0] es;
    cyc++;
    if (base_wr && base_wdata == 32'h0) exp_exec = 0;
    mem_rvalid = rv_pend;
    if (rv_pend) mem_rdata = sw(op_mem[rd_slot]);
    rv_pend = 0;
    mem_ready = stall ? (cyc % 3 == 0) : 1'b1;
    if (mem_req && mem_ready) begin
      reqs++;
      ea = {cur_pfn, 12'h000} + AW'(exp_exec[5:0]) * 64;
      if (!mem_we) begin
        if (mem_addr != ea) mem_errs++;
        rd_slot = mem_addr[11:6];
        rv_pend = 1;
      end else begin
        es = (op_mem[exp_exec[5:0]] == 0) ? BAD : stub_status;
        if (mem_addr != ea + 4 || mem_wdata != sw(es)) mem_errs++;
        exp_exec++;
        writes++;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_base(input logic [31:0] v);
    @(posedge clk); #2 base_wr = 1; base_wdata = sw(v);
    if (v != 0) cur_pfn = v;
    @(posedge clk); #2 base_wr = 0;
  endtask

  task automatic wr_db(input logic [31:0] v);
    @(posedge clk); #2 db_wr = 1; db_wdata = sw(v);
    @(posedge clk); #2 db_wr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int r0;
    for (int i = 0; i < 64; i++) op_mem[i] = 32'h100 + i;
    op_mem[7] = 0;
    idle(3);
    #2 rst_n = 1;
    idle(1);
    // R10 reset state
    check("R10 event", event_count, 0);
    check("R10 base", base_rdata, 0);
    check("R10 req", {31'b0, mem_req}, 0);
    check("R10 err", {31'b0, db_err}, 0);
    // R6 doorbell ignored with no base
    wr_db(4); idle(20);
    check("R6 reqs", reqs, 0);
    wr_base(PFN); idle(20);
    check("R6 event", event_count, 0);
    // R1 big-endian base readback
    check("R1 base readback", base_rdata, sw(PFN));
    // R2 R3 R4 R5 R8 table
    for (int i = 0; i < 8; i++) begin
      wr_db(VEC[i][64:33]);
      idle(350);
      check("R4 R1 event count", event_count, sw(VEC[i][32:1]));
      check("R8 R5 db_err", {31'b0, db_err}, {31'b0, VEC[i][0]});
    end
    check("R2 R3 memory traffic", mem_errs, 0);
    check("R4 writes match count", writes, 81);
    // R9 throttled port
    stall = 1;
    wr_db(86); idle(150);
    check("R9 stalled count", event_count, sw(32'd86));
    check("R9 R2 stalled traffic", mem_errs, 0);
    stall = 0;
    // R7 abort mid-batch
    wr_db(126); idle(30);
    wr_base(0);
    check("R7 dev_reset", {31'b0, dev_reset}, 1);
    check("R7 event", event_count, 0);
    check("R7 base", base_rdata, 0);
    idle(3);
    check("R7 pulse width", {31'b0, dev_reset}, 0);
    r0 = reqs; idle(20);
    check("R7 no requests", reqs, r0);
    // R7 restart from zero counts
    wr_base(PFN); wr_db(2); idle(40);
    check("R7 restart count", event_count, sw(32'd2));
    check("R7 R2 restart traffic", mem_errs, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule